// File: doc/BRIEF.md
# Rectangular Block Copy Engine

The engine copies a packed rectangular image from a source buffer into a window of a larger framebuffer. The framebuffer is `FB_W` pixels wide, and each pixel takes 2 or 3 bytes. The copy moves 16-bit elements. Two address walkers run over the same element grid: one for the source and one for the destination.

The source side steps one element at a time for the whole image, because the image is packed with no gap between rows. The destination side steps one element at a time within a row. At the end of a row it adds a row-end increment that jumps to the start of the same column span on the next framebuffer row.

A job is set up on the configuration pins and launched with a one-cycle `start` pulse. `busy` stays high until the final destination write has been accepted. `done` and `err` are sticky flags that are cleared by pulsing their clear pins.

The memory side uses three valid/ready channels: read request, read response and write request. A transfer happens on a cycle where valid and ready are both high. Back-pressure rules:
- While a request's valid is high and its ready is low, the address, and for writes the data, stay unchanged.
- Valid is never withdrawn before the request is accepted.
- The engine takes a read response only while it is waiting for one.
- The engine has at most one read in flight.

Top module: `blit2d_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `rd_req_valid` and `wr_req_valid` are all low.
- R2: A job moves exactly `width*bpp/2` elements per row and `height` rows. Each element is one read followed by one write. `cfg_bpp_sel` selects the bytes per pixel: 0 gives 2 bytes and 1 gives 3 bytes.
- R3: Read addresses start at `cfg_src_base` and rise by 2 for every element, including across row ends.
- R4: The first write address is `cfg_dst_base + (cfg_x with bit 0 cleared)*bpp + cfg_y*FB_W*bpp`.
- R5: Within a row, write addresses rise by 2. After the last element of a row, the next write address is the previous one plus `(FB_W - width)*bpp + 2`.
- R6: Each write carries the data of the matching read, in order. No new read is requested until the previous element's write has been accepted.
- R7: A request held with valid high and ready low keeps its valid, address and data unchanged on the next cycle.
- R8: `busy` rises in the cycle after an accepted `start`. It falls, and `done` rises, in the cycle after the last write is accepted.
- R9: A job with a zero element count per row or zero height makes no memory request, never raises `busy`, and sets `done` in the cycle after `start`.
- R10: A job whose row byte count is odd (3-byte pixels with an odd width) makes no memory request and sets `err`. It does not set `done`.
- R11: Pulsing `done_clr` or `err_clr` clears its flag. If a flag is set and cleared in the same cycle, the set wins.
- R12: A `start` pulse while `busy` is high is ignored, and the running job continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch pulse; taken only when idle |
| cfg_src_base | input | ADDR_W | Byte address of the packed source image |
| cfg_dst_base | input | ADDR_W | Byte address of framebuffer pixel (0,0) |
| cfg_x | input | DIM_W | Destination column in pixels |
| cfg_y | input | DIM_W | Destination row in pixels |
| cfg_width | input | DIM_W | Image width in pixels |
| cfg_height | input | DIM_W | Image height in rows |
| cfg_bpp_sel | input | 1 | 0: 2 bytes/pixel, 1: 3 bytes/pixel |
| done_clr | input | 1 | Clears `done` |
| err_clr | input | 1 | Clears `err` |
| busy | output | 1 | Job running |
| done | output | 1 | Sticky completion flag |
| err | output | 1 | Sticky configuration error flag |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_ready | output | 1 | Engine can take read data |
| rd_resp_data | input | DATA_W | Read data |
| wr_req_valid | output | 1 | Write request valid |
| wr_req_ready | input | 1 | Write request accepted |
| wr_req_addr | output | ADDR_W | Write byte address |
| wr_req_data | output | DATA_W | Write data |

## Verification
A wrong walker count shows at the first row end. The destination address jumps one element early or late, or the last write lands at a different element count than the bench expects. A wrong row-end increment shows on the first write of the second row. A sequencer that loses its place shows up immediately in one of two ways:
- a read issued before the previous write has been accepted, or
- a `done` that appears before, or long after, the final write.

Each of these is caught on the cycle of the offending handshake.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_READ  = 2'd1,
    S_WAIT  = 2'd2,
    S_WRITE = 2'd3
  } blit_state_t;
endpackage

// File: rtl/blit_walker.sv
// Element grid position tracker shared by both address sides.
module blit_walker #(
  parameter int CNT_W = 11,
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] x_total,
  input  logic [ROW_W-1:0] y_total,
  output logic             row_end,
  output logic             last
);
  logic [CNT_W-1:0] xt, xp;
  logic [ROW_W-1:0] yt, yp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xt <= '0; xp <= '0; yt <= '0; yp <= '0;
    end else if (load) begin
      xt <= x_total; yt <= y_total; xp <= '0; yp <= '0;
    end else if (step) begin
      if (row_end) begin
        xp <= '0;
        yp <= yp + ROW_W'(1);
      end else begin
        xp <= xp + CNT_W'(1);
      end
    end
  end

  assign row_end = (xp == xt - CNT_W'(1));
  assign last    = row_end && (yp == yt - ROW_W'(1));

  // R2: the row position never passes the row length while counting
  a_r2_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !row_end) |=> (xp != '0));
endmodule

// File: rtl/blit_addr.sv
// Byte address accumulator: fixed in-row step, configurable row-end step.
module blit_addr #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] row_inc,
  input  logic              step,
  input  logic              row_end,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] row_inc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0; row_inc_q <= '0;
    end else if (load) begin
      addr <= base; row_inc_q <= row_inc;
    end else if (step) begin
      addr <= addr + (row_end ? row_inc_q : ADDR_W'(STEP));
    end
  end

  // R3: the address only moves on a load or an element step
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(addr));
endmodule

// File: rtl/blit2d_engine.sv
module blit2d_engine
  import blit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int DIM_W  = 10,
  parameter int FB_W   = 320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_src_base,
  input  logic [ADDR_W-1:0] cfg_dst_base,
  input  logic [DIM_W-1:0]  cfg_x,
  input  logic [DIM_W-1:0]  cfg_y,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic              cfg_bpp_sel,
  input  logic              done_clr,
  input  logic              err_clr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_resp_valid,
  output logic              rd_resp_ready,
  input  logic [DATA_W-1:0] rd_resp_data,
  output logic              wr_req_valid,
  input  logic              wr_req_ready,
  output logic [ADDR_W-1:0] wr_req_addr,
  output logic [DATA_W-1:0] wr_req_data
);
  localparam int ELEM_BYTES = DATA_W / 8;
  localparam int CNT_W      = DIM_W + 1;

  blit_state_t       state;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] bpp, row_bytes, dst_start, dst_row_inc;
  logic [CNT_W-1:0]  xcnt;
  logic              row_odd, empty, load, step, row_end, last;

  always_comb begin
    bpp         = cfg_bpp_sel ? ADDR_W'(3) : ADDR_W'(2);
    row_bytes   = ADDR_W'(cfg_width) * bpp;
    xcnt        = CNT_W'(row_bytes >> 1);
    row_odd     = row_bytes[0];
    empty       = (xcnt == '0) || (cfg_height == '0);
    dst_start   = cfg_dst_base
                + ADDR_W'({cfg_x[DIM_W-1:1], 1'b0}) * bpp
                + ADDR_W'(cfg_y) * ADDR_W'(FB_W) * bpp;
    dst_row_inc = (ADDR_W'(FB_W) - ADDR_W'(cfg_width)) * bpp + ADDR_W'(ELEM_BYTES);
  end

  assign load = (state == S_IDLE) && start && !row_odd && !empty;
  assign step = (state == S_WRITE) && wr_req_ready;

  blit_walker #(.CNT_W(CNT_W), .ROW_W(DIM_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .x_total(xcnt), .y_total(cfg_height), .row_end(row_end), .last(last)
  );

  blit_addr #(.ADDR_W(ADDR_W), .STEP(ELEM_BYTES)) u_src (
    .clk(clk), .rst_n(rst_n), .load(load), .base(cfg_src_base),
    .row_inc(ADDR_W'(ELEM_BYTES)), .step(step), .row_end(row_end),
    .addr(rd_req_addr)
  );

  blit_addr #(.ADDR_W(ADDR_W), .STEP(ELEM_BYTES)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(load), .base(dst_start),
    .row_inc(dst_row_inc), .step(step), .row_end(row_end),
    .addr(wr_req_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      done   <= 1'b0;
      err    <= 1'b0;
      data_q <= '0;
    end else begin
      if (done_clr) done <= 1'b0;
      if (err_clr)  err  <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          if (row_odd)    err   <= 1'b1;
          else if (empty) done  <= 1'b1;
          else            state <= S_READ;
        end
        S_READ:  if (rd_req_ready) state <= S_WAIT;
        S_WAIT:  if (rd_resp_valid) begin
          data_q <= rd_resp_data;
          state  <= S_WRITE;
        end
        S_WRITE: if (wr_req_ready) begin
          if (last) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            state <= S_READ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy          = (state != S_IDLE);
  assign rd_req_valid  = (state == S_READ);
  assign rd_resp_ready = (state == S_WAIT);
  assign wr_req_valid  = (state == S_WRITE);
  assign wr_req_data   = data_q;

  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
  a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_valid && !wr_req_ready) |=>
      (wr_req_valid && $stable(wr_req_addr) && $stable(wr_req_data)));
  a_r6_no_read_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_resp_valid && rd_resp_ready) |=> (!rd_req_valid && wr_req_valid));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req_valid && !wr_req_valid && !rd_resp_ready));
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && $past(busy)) |-> (!busy && $past(wr_req_valid && wr_req_ready)));
endmodule

// File: tb/blit2d_engine_test.sv
`timescale 1ns/1ps
module blit2d_engine_test;
  localparam int FBW = 320;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, cfg_bpp_sel = 0, done_clr = 0, err_clr = 0;
  logic [31:0] cfg_src_base = 0, cfg_dst_base = 0;
  logic [9:0]  cfg_x = 0, cfg_y = 0, cfg_width = 0, cfg_height = 0;
  logic busy, done, err;
  logic rd_req_valid, rd_req_ready = 0, rd_resp_valid = 0, rd_resp_ready;
  logic wr_req_valid, wr_req_ready = 0;
  logic [31:0] rd_req_addr, wr_req_addr;
  logic [15:0] rd_resp_data = 0, wr_req_data;

  int checks = 0, fails = 0;
  int n_rd = 0, n_wr = 0;
  logic [31:0] j_src, j_dst;
  int j_x, j_y, j_w, j_h, j_bpp;

  always #2 clk = ~clk;

  blit2d_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_x(cfg_x), .cfg_y(cfg_y), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_bpp_sel(cfg_bpp_sel), .done_clr(done_clr), .err_clr(err_clr),
    .busy(busy), .done(done), .err(err),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_ready(rd_resp_ready), .rd_resp_data(rd_resp_data),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
    .wr_req_addr(wr_req_addr), .wr_req_data(wr_req_data)
  );

  function automatic logic [15:0] mem_val(logic [31:0] a);
    return (a[15:0] * 16'd3) ^ a[31:16] ^ 16'h5A3C;
  endfunction
  function automatic int row_elems();
    return (j_w * j_bpp) / 2;
  endfunction
  function automatic logic [31:0] exp_src(int n);
    return j_src + 32'(2 * n);
  endfunction
  function automatic logic [31:0] exp_dst(int n);
    int r = n / row_elems();
    int c = n % row_elems();
    return j_dst + 32'((j_x & ~1) * j_bpp) + 32'((j_y + r) * FBW * j_bpp) + 32'(2 * c);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: decides readies at negedge, logs handshakes, checks traffic
  initial begin
    bit pend = 0, rsp_go = 0;
    int dly = 0;
    logic [31:0] pa = 0;
    forever begin
      @(negedge clk);
      if (rsp_go) begin rd_resp_valid = 0; rsp_go = 0; end
      if (pend) begin
        if (dly == 0) begin rd_resp_valid = 1; rd_resp_data = mem_val(pa); pend = 0; end
        else dly--;
      end
      rd_req_ready = ($urandom % 4) != 0;
      if (rd_req_valid && rd_req_ready) begin
        check(n_rd == n_wr, "R6 single outstanding read", 32'(n_rd), 32'(n_wr));
        check(rd_req_addr == exp_src(n_rd), "R3 read address", rd_req_addr, exp_src(n_rd));
        pa = rd_req_addr; pend = 1; dly = $urandom % 3; n_rd++;
      end
      wr_req_ready = ($urandom % 3) != 0;
      if (wr_req_valid && wr_req_ready) begin
        check(wr_req_addr == exp_dst(n_wr), "R4/R5 write address", wr_req_addr, exp_dst(n_wr));
        check(wr_req_data == mem_val(exp_src(n_wr)), "R6 write data", 32'(wr_req_data),
              32'(mem_val(exp_src(n_wr))));
        n_wr++;
      end
      if (rd_resp_valid && rd_resp_ready) rsp_go = 1;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  task automatic set_cfg(input logic [31:0] s, input logic [31:0] d, input int x, input int y,
                         input int w, input int h, input int bsel);
    j_src = s; j_dst = d; j_x = x; j_y = y; j_w = w; j_h = h; j_bpp = bsel ? 3 : 2;
    cfg_src_base = s; cfg_dst_base = d; cfg_x = 10'(x); cfg_y = 10'(y);
    cfg_width = 10'(w); cfg_height = 10'(h); cfg_bpp_sel = bsel[0];
    n_rd = 0; n_wr = 0;
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic clear_done();
    done_clr = 1; @(negedge clk); done_clr = 0;
    check(done == 0, "R11 done cleared", 32'(done), 0);
  endtask

  task automatic run_job(input logic [31:0] s, input logic [31:0] d, input int x, input int y,
                         input int w, input int h, input int bsel, input bit restart);
    int total, guard;
    set_cfg(s, d, x, y, w, h, bsel);
    total = row_elems() * h;
    @(negedge clk);
    pulse_start();
    check(busy == 1, "R8 busy after start", 32'(busy), 1);
    if (restart) begin
      // R12: a second start with other settings while busy
      cfg_src_base = 32'h7000; cfg_width = 10'd2; cfg_height = 10'd1; cfg_x = 10'd9;
      pulse_start();
    end
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    check(done == 1 && busy == 0, "R8 done and idle at end", {busy, done}, 32'h1);
    check(n_wr == total && n_rd == total, "R2 element count", 32'(n_wr), 32'(total));
    repeat (3) @(negedge clk);
    check(n_rd == total && !busy, restart ? "R12 no extra job" : "R2 no extra access",
          32'(n_rd), 32'(total));
    clear_done();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !err && !rd_req_valid && !wr_req_valid, "R1 reset state",
          {busy, done, err, rd_req_valid, wr_req_valid}, 0);

    // directed corners
    run_job(32'h1000, 32'h2_0000, 0, 0, 1, 1, 0, 0);       // single element
    run_job(32'h1100, 32'h2_0000, 7, 3, 4, 3, 0, 0);       // odd x rounds down (R4)
    run_job(32'h1200, 32'h4_0000, 5, 1, 6, 4, 1, 0);       // 3-byte pixels (R5)
    run_job(32'h1300, 32'h8_0000, 0, 239, FBW, 1, 1, 0);   // full-width row
    run_job(32'h1400, 32'h9_0000, 11, 2, 5, 3, 0, 1);      // restart while busy (R12)

    // R9: zero height and zero width
    set_cfg(32'h0, 32'h0, 0, 0, 4, 0, 0);
    @(negedge clk); pulse_start();
    check(done == 1 && busy == 0, "R9 zero height done", {busy, done}, 1);
    repeat (4) @(negedge clk);
    check(n_rd == 0 && n_wr == 0, "R9 no access", 32'(n_rd + n_wr), 0);
    // R11: set wins over a clear in the same cycle
    cfg_width = 0; cfg_height = 10'd3;
    start = 1; done_clr = 1; @(negedge clk); start = 0; done_clr = 0;
    check(done == 1, "R11 set beats clear", 32'(done), 1);
    clear_done();

    // R10: odd row byte count
    set_cfg(32'h0, 32'h0, 0, 0, 5, 2, 1);
    @(negedge clk); pulse_start();
    check(err == 1 && done == 0 && busy == 0, "R10 err raised", {busy, done, err}, 1);
    repeat (4) @(negedge clk);
    check(n_rd == 0, "R10 no access", 32'(n_rd), 0);
    err_clr = 1; @(negedge clk); err_clr = 0;
    check(err == 0, "R11 err cleared", 32'(err), 0);

    // constrained random jobs
    for (int k = 0; k < 24; k++) begin
      int bs = $urandom % 2;
      int w = 1 + ($urandom % 12);
      if (bs == 1) w = w & ~1;
      if (w == 0) w = 2;
      run_job($urandom & 32'h00FF_FFFE, $urandom & 32'h0FF0_0000, $urandom % 300,
              $urandom % 230, w, 1 + ($urandom % 6), bs, 0);
    end
    summary();
  end
endmodule